// File: doc/BRIEF.md
# Switching-Cycle PID Duty Compensator with Freeze and Stimulus Injection

This block closes the voltage loop of a digitally controlled switching converter. Once per switching period a sampled output-voltage error arrives with a one-cycle strobe. The block evaluates a parallel-form discrete PID law and delivers a 12-bit unsigned duty command to a digital pulse-width modulator. The proportional, integral and derivative gains are signed fixed-point words. An autotuning engine writes them at run time. A load strobe captures all three gains together, and the block applies them as a set at the next sample boundary.

For open-loop frequency-response identification, a freeze input can be raised on a sample. The compensator state then stops advancing, and the duty command becomes the last compensator output plus a signed perturbation word supplied from outside, saturated to the PWM range. When freeze is released, the compensator resumes from the state it held before the freeze. An integral-only setting, with the proportional and derivative gains at zero, is a normal operating point.

Top module: `pid_duty_ctrl`

## Requirements
- R1: After synchronous reset, duty_out is 0 and duty_valid is 0. The integrator, the previous-error register, and the active and pending gains are all zero, so a first sample with no gain load yields a duty of 0.
- R2: When sample_valid is high in the cycle ending at clock edge N, duty_valid is high for exactly the cycle after edge N+2. duty_valid is never high at any other time. Back-to-back samples give back-to-back valid cycles.
- R3: The compensator value is u = KP·e + A + KD·(e − e_prev). A is the clamped running sum of KI·e, and e_prev is the error of the last unfrozen sample. Gains are two's complement with 10 fractional bits. The full-precision sum is rounded once, by adding 512 and shifting right arithmetically by 10.
- R4: The rounded compensator value is saturated to 0..4095 before it becomes the duty command.
- R5: After each update, the integrator sum A is clamped to the range 0 .. 4095·1024, so it cannot wind up beyond what the saturated output can express.
- R6: gain_load captures kp_in, ki_in and kd_in together. The captured set becomes active on the first sample whose strobe cycle is strictly later than the load cycle. A load coincident with a sample affects only later samples. All three gains always change on the same sample.
- R7: A sample taken with freeze_en high yields duty = clamp(H + stim_in, 0, 4095). H is the saturated compensator output of the last unfrozen sample, and is 0 after reset. Such a sample changes neither the integrator, nor the previous error, nor H.
- R8: The first unfrozen sample after a freeze computes from the integrator and previous error that were present before the freeze began.
- R9: duty_out changes only in a cycle in which duty_valid is high. Gain loads and input changes without a sample leave it unchanged.
- R10: With KP = KD = 0, the duty command is the rounded and clamped integrator sum alone, and grows by KI·e per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe, one per switching period |
| err_in | input | ERR_W (12) | Signed sampled voltage error |
| freeze_en | input | 1 | Identification mode, sampled with sample_valid |
| stim_in | input | STIM_W (12) | Signed perturbation word, sampled with sample_valid |
| gain_load | input | 1 | Captures the three gain inputs |
| kp_in | input | GAIN_W (16) | Proportional gain, 10 fractional bits |
| ki_in | input | GAIN_W (16) | Integral gain, 10 fractional bits |
| kd_in | input | GAIN_W (16) | Derivative gain, 10 fractional bits |
| duty_out | output | OUT_W (12) | Unsigned duty command |
| duty_valid | output | 1 | Duty updated this cycle |

## Verification
The bench builds the block with its defaults: 12-bit error and stimulus, 16-bit gains with 10 fractional bits, and a 12-bit duty. With these values, a full-scale error times the largest gain drives both saturation limits. The same values let the integrator hit its upper clamp in a few samples. Half-LSB products such as 0.5·3 show the single round-half-up step. A 12-bit stimulus can push a held duty past either end of the PWM range while frozen.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int NUM_GAINS = 3;
  localparam int IDX_P = 0;
  localparam int IDX_I = 1;
  localparam int IDX_D = 2;
endpackage

// File: rtl/pid_gain_bank.sv
module pid_gain_bank #(
  parameter int GAIN_W = 16,
  parameter int NUM    = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load_i,
  input  logic                         apply_i,
  input  logic [NUM-1:0][GAIN_W-1:0]   gains_i,
  output logic [NUM-1:0][GAIN_W-1:0]   active_o
);
  logic              pending_q;
  logic [GAIN_W-1:0] shadow_q [NUM];
  logic [GAIN_W-1:0] active_q [NUM];

  always_ff @(posedge clk) begin
    if (rst)          pending_q <= 1'b0;
    else if (load_i)  pending_q <= 1'b1;
    else if (apply_i) pending_q <= 1'b0;
  end

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q[g] <= '0;
        active_q[g] <= '0;
      end else begin
        if (load_i)               shadow_q[g] <= gains_i[g];
        if (apply_i && pending_q) active_q[g] <= shadow_q[g];
      end
    end
    assign active_o[g] = active_q[g];
  end

  // R6: active set moves only at a sample boundary with a pending load
  p_gain_atomic_r6: assert property (@(posedge clk) disable iff (rst)
    !(apply_i && pending_q) |=> $stable(active_o));
endmodule

// File: rtl/pid_integrator.sv
module pid_integrator #(
  parameter int SUM_W = 32,
  parameter int OUT_W = 12,
  parameter int FRAC  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_i,
  input  logic signed [SUM_W-1:0] inc_i,
  output logic signed [SUM_W-1:0] acc_next_o
);
  localparam longint ACC_MAX_L = ((longint'(1) << OUT_W) - 1) << FRAC;
  localparam logic signed [SUM_W:0] ACC_MAX = (SUM_W+1)'(ACC_MAX_L);

  logic signed [SUM_W-1:0] acc_q;
  logic signed [SUM_W:0]   raw;

  assign raw = $signed({acc_q[SUM_W-1], acc_q}) + $signed({inc_i[SUM_W-1], inc_i});

  always_comb begin
    if (raw < 0)            acc_next_o = '0;
    else if (raw > ACC_MAX) acc_next_o = ACC_MAX[SUM_W-1:0];
    else                    acc_next_o = raw[SUM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (upd_i) acc_q <= acc_next_o;
  end

  // R5: stored sum stays inside the anti-windup window
  p_acc_range_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_q >= 0) && ($signed({acc_q[SUM_W-1], acc_q}) <= ACC_MAX));
  // R7: frozen or idle cycles leave the integrator alone
  p_acc_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(acc_q));
endmodule

// File: rtl/pid_duty_out.sv
module pid_duty_out #(
  parameter int SUM_W  = 32,
  parameter int OUT_W  = 12,
  parameter int STIM_W = 12,
  parameter int FRAC   = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid_i,
  input  logic                     frz_i,
  input  logic signed [SUM_W-1:0]  sum_i,
  input  logic signed [STIM_W-1:0] stim_i,
  output logic [OUT_W-1:0]         duty_o,
  output logic                     valid_o
);
  localparam int RW    = SUM_W + 1;
  localparam int INJ_W = ((OUT_W > STIM_W) ? OUT_W : STIM_W) + 2;
  localparam logic signed [RW-1:0]    HALF    = RW'(longint'(1) << (FRAC-1));
  localparam logic signed [RW-1:0]    MAX_R   = RW'((longint'(1) << OUT_W) - 1);
  localparam logic signed [INJ_W-1:0] MAX_I   = INJ_W'((longint'(1) << OUT_W) - 1);

  logic signed [RW-1:0]    rnd;
  logic signed [INJ_W-1:0] inj;
  logic [OUT_W-1:0]        comp_sat, inj_sat, hold_q;

  assign rnd = ($signed({sum_i[SUM_W-1], sum_i}) + HALF) >>> FRAC;
  assign inj = INJ_W'($signed({1'b0, hold_q})) + INJ_W'(stim_i);

  always_comb begin
    if (rnd < 0)          comp_sat = '0;
    else if (rnd > MAX_R) comp_sat = MAX_R[OUT_W-1:0];
    else                  comp_sat = rnd[OUT_W-1:0];
    if (inj < 0)          inj_sat  = '0;
    else if (inj > MAX_I) inj_sat  = MAX_I[OUT_W-1:0];
    else                  inj_sat  = inj[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_o  <= '0;
      hold_q  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        duty_o <= frz_i ? inj_sat : comp_sat;
        if (!frz_i) hold_q <= comp_sat;
      end
    end
  end

  // R7: held steady-state value is untouched by a frozen sample
  p_hold_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && frz_i) |=> $stable(hold_q));
endmodule

// File: rtl/pid_duty_ctrl.sv
module pid_duty_ctrl
  import pid_pkg::*;
#(
  parameter int ERR_W  = 12,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 10,
  parameter int OUT_W  = 12,
  parameter int STIM_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_valid,
  input  logic signed [ERR_W-1:0]  err_in,
  input  logic                     freeze_en,
  input  logic signed [STIM_W-1:0] stim_in,
  input  logic                     gain_load,
  input  logic signed [GAIN_W-1:0] kp_in,
  input  logic signed [GAIN_W-1:0] ki_in,
  input  logic signed [GAIN_W-1:0] kd_in,
  output logic [OUT_W-1:0]         duty_out,
  output logic                     duty_valid
);
  localparam int SUM_W = GAIN_W + ERR_W + 4;

  logic [NUM_GAINS-1:0][GAIN_W-1:0] gains_pack, gains_act;
  logic signed [GAIN_W-1:0] kp_a, ki_a, kd_a;

  assign gains_pack[IDX_P] = kp_in;
  assign gains_pack[IDX_I] = ki_in;
  assign gains_pack[IDX_D] = kd_in;

  pid_gain_bank #(.GAIN_W(GAIN_W), .NUM(NUM_GAINS)) u_gains (
    .clk(clk), .rst(rst), .load_i(gain_load), .apply_i(sample_valid),
    .gains_i(gains_pack), .active_o(gains_act));

  assign kp_a = $signed(gains_act[IDX_P]);
  assign ki_a = $signed(gains_act[IDX_I]);
  assign kd_a = $signed(gains_act[IDX_D]);

  // stage 1: capture sample
  logic                     v1, frz1;
  logic signed [ERR_W-1:0]  err1;
  logic signed [STIM_W-1:0] stim1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; frz1 <= 1'b0; err1 <= '0; stim1 <= '0;
    end else begin
      v1 <= sample_valid;
      if (sample_valid) begin
        err1  <= err_in;
        frz1  <= freeze_en;
        stim1 <= stim_in;
      end
    end
  end

  // stage 2: products
  logic                     v2, frz2;
  logic signed [STIM_W-1:0] stim2;
  logic signed [ERR_W-1:0]  eprev;
  logic signed [SUM_W-1:0]  pkp, pki, pkd, diff;

  assign diff = SUM_W'(err1) - SUM_W'(eprev);

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; frz2 <= 1'b0; stim2 <= '0; eprev <= '0;
      pkp <= '0; pki <= '0; pkd <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        pkp   <= SUM_W'(kp_a) * SUM_W'(err1);
        pki   <= SUM_W'(ki_a) * SUM_W'(err1);
        pkd   <= SUM_W'(kd_a) * diff;
        frz2  <= frz1;
        stim2 <= stim1;
        if (!frz1) eprev <= err1;
      end
    end
  end

  // stage 3: accumulate, sum, round, saturate
  logic signed [SUM_W-1:0] acc_next, sum;

  pid_integrator #(.SUM_W(SUM_W), .OUT_W(OUT_W), .FRAC(FRAC)) u_integ (
    .clk(clk), .rst(rst), .upd_i(v2 && !frz2), .inc_i(pki), .acc_next_o(acc_next));

  assign sum = pkp + acc_next + pkd;

  pid_duty_out #(.SUM_W(SUM_W), .OUT_W(OUT_W), .STIM_W(STIM_W), .FRAC(FRAC)) u_out (
    .clk(clk), .rst(rst), .valid_i(v2), .frz_i(frz2), .sum_i(sum), .stim_i(stim2),
    .duty_o(duty_out), .valid_o(duty_valid));

  // R2: every valid pulse traces back to a strobe three edges earlier
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    duty_valid |-> $past(sample_valid, 3));
  // R9: command only moves with a valid pulse
  p_duty_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !duty_valid |-> $stable(duty_out));
  // R7: previous error is frozen along with the integrator
  p_eprev_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (v1 && frz1) |=> $stable(eprev));
endmodule

// File: tb/pid_duty_ctrl_tb.sv
module pid_duty_ctrl_tb_top;
  localparam int ERR_W = 12, GAIN_W = 16, OUT_W = 12, STIM_W = 12;
  localparam longint ACC_MAX = 4095 * 1024;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic sample_valid = 1'b0, freeze_en = 1'b0, gain_load = 1'b0;
  logic signed [ERR_W-1:0]  err_in = '0;
  logic signed [STIM_W-1:0] stim_in = '0;
  logic signed [GAIN_W-1:0] kp_in = '0, ki_in = '0, kd_in = '0;
  logic [OUT_W-1:0] duty_out;
  logic duty_valid;

  pid_duty_ctrl dut_i (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .err_in(err_in),
    .freeze_en(freeze_en), .stim_in(stim_in), .gain_load(gain_load),
    .kp_in(kp_in), .ki_in(ki_in), .kd_in(kd_in),
    .duty_out(duty_out), .duty_valid(duty_valid));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference state
  longint skp = 0, ski = 0, skd = 0, akp = 0, aki = 0, akd = 0;
  longint acc = 0, ep = 0, hold = 0, exp_d = 0;
  bit pend = 0, chk_on = 0, done = 0;
  longint q_val[$];
  int     q_due[$];
  string  q_tag[$];
  string  tag = "R1";
  int n_run = 0, n_fail = 0;

  function automatic longint clip(longint v, longint lo, longint hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic check(bit ok, string rq, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      bit ev;
      string rq;
      ev = 0;
      rq = duty_valid ? "R2" : "R9";
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        ev = 1; exp_d = q_val[0]; rq = q_tag[0];
        void'(q_due.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
      end
      check(duty_valid == ev, "R2", longint'(duty_valid), longint'(ev));
      check(longint'(duty_out) == exp_d, rq, longint'(duty_out), exp_d);
    end
  end

  task automatic model_sample(longint e, bit fz, longint st);
    longint o, s;
    if (pend) begin akp = skp; aki = ski; akd = skd; pend = 0; end
    if (fz) o = clip(hold + st, 0, 4095);
    else begin
      acc  = clip(acc + aki * e, 0, ACC_MAX);
      s    = akp * e + acc + akd * (e - ep);
      o    = clip((s + 512) >>> 10, 0, 4095);
      hold = o;
      ep   = e;
    end
    q_val.push_back(o); q_due.push_back(cyc + 3); q_tag.push_back(tag);
  endtask

  task automatic step(bit sv, longint e, bit fz, longint st, bit ld,
                      longint kp, longint ki, longint kd);
    sample_valid = sv; err_in = e[ERR_W-1:0]; freeze_en = fz; stim_in = st[STIM_W-1:0];
    gain_load = ld; kp_in = kp[GAIN_W-1:0]; ki_in = ki[GAIN_W-1:0]; kd_in = kd[GAIN_W-1:0];
    if (sv) model_sample(e, fz, st);
    if (ld) begin skp = kp; ski = ki; skd = kd; pend = 1; end
    @(negedge clk);
    sample_valid = 0; gain_load = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic samp(longint e);
    step(1, e, 0, 0, 0, 0, 0, 0); idle(3);
  endtask
  task automatic samp_f(longint e, longint st);
    step(1, e, 1, st, 0, 0, 0, 0); idle(3);
  endtask
  task automatic load(longint kp, longint ki, longint kd);
    step(0, 0, 0, 0, 1, kp, ki, kd); idle(1);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R2: watchdog expired, actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 0;
    idle(1);
    tag = "R1";
    check(duty_out == 0, "R1", longint'(duty_out), 0);
    check(duty_valid == 0, "R1", longint'(duty_valid), 0);
    chk_on = 1;
    samp(500);                       // R1: zero gains after reset

    tag = "R3";
    load(1024, 0, 0); samp(100);     // 1.0 * 100
    load(512, 0, 0);  samp(3);       // 1.5 rounds half-up to 2
    samp(7); samp(-1);               // -0.5 rounds to 0
    tag = "R4"; samp(-3);            // negative clamps to 0

    tag = "R10";
    load(0, 256, 0); samp(10); samp(10); samp(10); samp(-4);

    tag = "R3";
    load(0, 0, 2048); samp(20); samp(20); samp(-30);
    load(700, 100, -300); samp(50); samp(-25); samp(80);

    tag = "R4";
    load(32767, 0, 0); samp(2047); samp(-2048);

    tag = "R5";
    load(0, 32767, 0); samp(2047); samp(2047); samp(2047); samp(-10); samp(-10);
    load(0, 32767, 0); samp(-2048); samp(-2048); samp(5);

    tag = "R6";
    load(1024, 0, 0); samp(0);
    step(1, 40, 0, 0, 1, 2048, 0, 0); idle(3);   // old gains still in force
    samp(40);                                    // new gains now
    step(0, 0, 0, 0, 1, -1024, 512, 1024);
    step(1, 60, 0, 0, 0, 0, 0, 0);               // load one cycle before sample
    idle(3);
    samp(30);

    tag = "R2";
    load(1024, 64, 256);
    step(1, 10, 0, 0, 0, 0, 0, 0);
    step(1, 200, 0, 0, 0, 0, 0, 0);
    step(1, -50, 0, 0, 0, 0, 0, 0);
    idle(4);

    tag = "R9";
    load(5000, 5000, 5000); load(-7, 3, 9);
    err_in = 12'sd900; stim_in = 12'sd77; freeze_en = 1; idle(6); freeze_en = 0;

    tag = "R7";
    load(1024, 128, 0); samp(300); samp(310);
    samp_f(900, 50); samp_f(-900, -200); samp_f(0, 2047); samp_f(5, -2048);
    load(0, 0, 0);  samp_f(0, 3);                // gain load while frozen still holds
    tag = "R8";
    load(1024, 128, 0);
    samp(310); samp(200);
    samp_f(10, 2047);
    tag = "R7"; samp_f(10, 2047);
    tag = "R8"; samp(-100);
    step(1, 15, 1, 100, 0, 0, 0, 0);
    step(1, 15, 0, 0, 0, 0, 0, 0);
    idle(5);

    chk_on = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule